// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block turns a virtual address into a physical address within the same clock cycle, using a small store of recently used page mappings. Any stored entry may hold any mapping. The page number of the incoming address is compared against every stored tag at once. On a match, the block returns the physical page number of that entry joined to the unchanged page offset. It also checks the entry's permission bits against the current privilege mode and the access type. In the same cycle it reports which address region the top address bits select.

When no entry matches, the block only raises a miss towards outside logic. That logic fetches the mapping and writes it back through the fill port. A fill goes into the lowest-numbered empty entry. When every entry is in use, a round-robin pointer picks the entry to replace. A flush input empties the whole store on a context change.

Top module: `xlat_buffer`

## Requirements
- R1: After reset every entry is empty, so every lookup returns hit_o = 0 and fault_o = 0.
- R2: A lookup hits when vaddr_i[42:13] equals the tag of a valid entry. On a hit, paddr_o = {stored 21-bit physical page, vaddr_i[12:0]}, combinationally in the same cycle.
- R3: region_o depends only on vaddr_i[63:62]. It is 2'b00 when bit 63 is 0 (user code), 2'b01 when bit 63 is 1 and bit 62 is 0 (kernel), and 2'b10 when both are 1 (user stack). It does not depend on hit or miss.
- R4: Permission bits are indexed by {user_i, write_i}. Bit 0 is kernel read, bit 1 kernel write, bit 2 user read and bit 3 user write. fault_o is 1 exactly when the lookup hits and the selected bit is 0.
- R5: On a miss, hit_o and fault_o are both 0.
- R6: An entry written by fill_i at a clock edge is visible to lookups from the next cycle on. It is not visible in the cycle in which fill_i is high.
- R7: A fill writes the lowest-numbered invalid entry whenever one exists.
- R8: When all entries are valid, a fill replaces the entry named by a pointer. The pointer is 0 after reset, advances by one after each such replacement and wraps after the last entry. Flush does not change it.
- R9: When several valid entries hold the same tag, the lowest-numbered one supplies the physical page and the permissions.
- R10: flush_i clears every valid bit at the clock edge. A fill requested in the same cycle as a flush is dropped.
- R11: vaddr_i bits 61 to 43 take no part in matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Invalidate all entries at the next edge |
| vaddr_i | input | 64 | Lookup virtual address |
| write_i | input | 1 | 1 = write access, 0 = read access |
| user_i | input | 1 | 1 = user mode, 0 = kernel mode |
| hit_o | output | 1 | A valid entry matches |
| fault_o | output | 1 | Hit with the required permission bit clear |
| paddr_o | output | 34 | Physical address, meaningful only on a hit |
| region_o | output | 2 | Decoded address region |
| fill_i | input | 1 | Write one mapping at the next edge |
| fill_vpn_i | input | 30 | Virtual page number to store |
| fill_ppn_i | input | 21 | Physical page number to store |
| fill_perm_i | input | 4 | Permission bits to store |

## Verification
The assertions rely on flush_i, fill_i, user_i and write_i being known (0 or 1) in every cycle after reset. The fill-visibility property also relies on no other port changing the stored entries between two adjacent cycles, except a flush. The stimulus drives every input at the falling edge and holds it stable through the following rising edge. It keeps all control inputs at defined values, including during reset. It deliberately sends a fill together with a flush, and it writes duplicate tags, so that the drop rule and the lowest-index priority are exercised and do not just lie idle.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

   localparam int PERM_W = 4;

   typedef enum logic [1:0] {
      REGION_UCODE = 2'b00,
      REGION_KERN  = 2'b01,
      REGION_USTK  = 2'b10
   } region_e;

   function automatic region_e region_of(input logic top1, input logic top0);
      if (!top1)      return REGION_UCODE;
      else if (!top0) return REGION_KERN;
      else            return REGION_USTK;
   endfunction

endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
   parameter int N  = 32,
   parameter int TW = 30,
   parameter int PW = 21,
   parameter int RW = 4
) (
   input  logic [N-1:0]  valid_i,
   input  logic [TW-1:0] tag_i  [N],
   input  logic [PW-1:0] ppn_i  [N],
   input  logic [RW-1:0] perm_i [N],
   input  logic [TW-1:0] key_i,
   output logic          hit_o,
   output logic [N-1:0]  sel_o,
   output logic [N-1:0]  match_o,
   output logic [PW-1:0] ppn_o,
   output logic [RW-1:0] perm_o
);

   logic [N-1:0] eq;

   for (genvar g = 0; g < N; g++) begin : g_cmp
      assign eq[g] = valid_i[g] && (tag_i[g] == key_i);
   end

   always_comb begin
      sel_o  = '0;
      ppn_o  = '0;
      perm_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (eq[i]) begin
            sel_o    = '0;
            sel_o[i] = 1'b1;
            ppn_o    = ppn_i[i];
            perm_o   = perm_i[i];
         end
      end
   end

   assign hit_o   = |eq;
   assign match_o = eq;

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
   parameter int N  = 32,
   parameter int IW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  valid_i,
   input  logic          fill_i,
   input  logic          flush_i,
   output logic [IW-1:0] victim_o
);

   logic [IW-1:0] rr_q;
   logic          has_free;

   always_comb begin
      has_free = 1'b0;
      victim_o = rr_q;
      for (int i = N - 1; i >= 0; i--) begin
         if (!valid_i[i]) begin
            has_free = 1'b1;
            victim_o = IW'(i);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rr_q <= '0;
      else if (fill_i && !flush_i && !has_free)
         rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + 1'b1;
   end

   // free slot is taken before any valid entry is replaced
   assert_victim_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_i && !(&valid_i)) |-> !valid_i[victim_o]);

   // pointer moves by exactly one step per replacement when full
   assert_rr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_i && !flush_i && (&valid_i)) |=>
         (rr_q == (($past(rr_q) == IW'(N - 1)) ? '0 : $past(rr_q) + 1'b1)));

endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer #(
   parameter int ENTRIES       = 32,
   parameter int ADDR_W        = 64,
   parameter int VA_W          = 43,
   parameter int PA_W          = 34,
   parameter int OFS_W         = 13,
   parameter bit REGION_DECODE = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     flush_i,
   input  logic [ADDR_W-1:0]        vaddr_i,
   input  logic                     write_i,
   input  logic                     user_i,
   output logic                     hit_o,
   output logic                     fault_o,
   output logic [PA_W-1:0]          paddr_o,
   output logic [1:0]               region_o,
   input  logic                     fill_i,
   input  logic [VA_W-OFS_W-1:0]    fill_vpn_i,
   input  logic [PA_W-OFS_W-1:0]    fill_ppn_i,
   input  logic [3:0]               fill_perm_i
);

   import xlat_pkg::*;

   localparam int TAG_W = VA_W - OFS_W;
   localparam int PPN_W = PA_W - OFS_W;
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   initial begin
      assert (ENTRIES >= 2) else $error("ENTRIES must be at least 2");
      assert (ADDR_W >= VA_W + 2) else $error("ADDR_W too small for region bits");
      assert (OFS_W > 0 && OFS_W < PA_W && OFS_W < VA_W) else $error("bad OFS_W");
      assert (PERM_W == 4) else $error("permission width mismatch");
   end

   logic [ENTRIES-1:0] valid_q;
   logic [TAG_W-1:0]   tag_q  [ENTRIES];
   logic [PPN_W-1:0]   ppn_q  [ENTRIES];
   logic [3:0]         perm_q [ENTRIES];

   logic [IDX_W-1:0]   victim;
   logic               hit;
   logic [ENTRIES-1:0] sel, match;
   logic [PPN_W-1:0]   hit_ppn;
   logic [3:0]         hit_perm;
   logic [TAG_W-1:0]   key;

   assign key = vaddr_i[VA_W-1:OFS_W];

   xlat_victim #(.N(ENTRIES), .IW(IDX_W)) u_victim (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid_i  (valid_q),
      .fill_i   (fill_i),
      .flush_i  (flush_i),
      .victim_o (victim)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         valid_q <= '0;
      else if (flush_i)
         valid_q <= '0;
      else if (fill_i)
         valid_q[victim] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (fill_i && !flush_i) begin
         tag_q[victim]  <= fill_vpn_i;
         ppn_q[victim]  <= fill_ppn_i;
         perm_q[victim] <= fill_perm_i;
      end
   end

   xlat_match #(.N(ENTRIES), .TW(TAG_W), .PW(PPN_W), .RW(4)) u_match (
      .valid_i (valid_q),
      .tag_i   (tag_q),
      .ppn_i   (ppn_q),
      .perm_i  (perm_q),
      .key_i   (key),
      .hit_o   (hit),
      .sel_o   (sel),
      .match_o (match),
      .ppn_o   (hit_ppn),
      .perm_o  (hit_perm)
   );

   assign hit_o   = hit;
   assign paddr_o = {hit_ppn, vaddr_i[OFS_W-1:0]};
   assign fault_o = hit && !hit_perm[{user_i, write_i}];

   if (REGION_DECODE) begin : g_region
      assign region_o = region_of(vaddr_i[ADDR_W-1], vaddr_i[ADDR_W-2]);
   end else begin : g_noregion
      assign region_o = REGION_UCODE;
   end

   logic unused_hi;
   assign unused_hi = ^vaddr_i[ADDR_W-1:VA_W];

   // checker state: the mapping written at the previous edge
   logic             chk_fill_q;
   logic [TAG_W-1:0] chk_vpn_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_fill_q <= 1'b0;
         chk_vpn_q  <= '0;
      end else begin
         chk_fill_q <= fill_i && !flush_i;
         chk_vpn_q  <= fill_vpn_i;
      end
   end

   assert_fault_needs_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> hit_o);

   assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> !hit_o);

   assert_fill_visible_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_fill_q && key == chk_vpn_q) |-> hit_o);

   assert_lowest_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> ($onehot0(sel) && (sel & match) != '0 && ((sel - 1'b1) & match) == '0));

endmodule

// File: tb/xlat_buffer_bench.sv
`timescale 1ns/1ps
module xlat_buffer_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush_i = 1'b0;
   logic [63:0] vaddr_i = '0;
   logic        write_i = 1'b0;
   logic        user_i = 1'b0;
   logic        hit_o, fault_o;
   logic [33:0] paddr_o;
   logic [1:0]  region_o;
   logic        fill_i = 1'b0;
   logic [29:0] fill_vpn_i = '0;
   logic [20:0] fill_ppn_i = '0;
   logic [3:0]  fill_perm_i = '0;

   always #2 clk = ~clk;

   xlat_buffer u_xlat_buffer (
      .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .vaddr_i(vaddr_i),
      .write_i(write_i), .user_i(user_i), .hit_o(hit_o), .fault_o(fault_o),
      .paddr_o(paddr_o), .region_o(region_o), .fill_i(fill_i),
      .fill_vpn_i(fill_vpn_i), .fill_ppn_i(fill_ppn_i), .fill_perm_i(fill_perm_i)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int n_cyc = 0;
   string cur_tag = "R1";

   // behavioural model
   bit        m_val  [32];
   bit [29:0] m_tag  [32];
   bit [20:0] m_ppn  [32];
   bit [3:0]  m_perm [32];
   int        m_ptr = 0;

   task automatic chk(string tag, longint act, longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic [29:0] pool(int k);
      return 30'h00ABC000 + 30'(k * 7919);
   endfunction

   function automatic [63:0] mkva(bit [29:0] vpn, bit [1:0] top, bit [18:0] mid, bit [12:0] off);
      return {top, mid, vpn, off};
   endfunction

   task automatic step(bit fl, bit fi, bit [29:0] fv, bit [20:0] fp, bit [3:0] fm,
                       bit [63:0] va, bit wr, bit us);
      int  idx;
      bit  found;
      @(negedge clk);
      flush_i = fl; fill_i = fi; fill_vpn_i = fv; fill_ppn_i = fp; fill_perm_i = fm;
      vaddr_i = va; write_i = wr; user_i = us;
      #1;
      idx = -1;
      for (int i = 0; i < 32; i++)
         if (idx < 0 && m_val[i] && m_tag[i] == va[42:13]) idx = i;
      chk(cur_tag, hit_o, idx >= 0);
      chk("R3", region_o, !va[63] ? 2'b00 : (!va[62] ? 2'b01 : 2'b10));
      if (idx >= 0) begin
         chk(cur_tag, paddr_o, {m_ppn[idx], va[12:0]});
         chk("R4", fault_o, !m_perm[idx][{us, wr}]);
      end else begin
         chk("R5", fault_o, 0);
      end
      @(posedge clk);
      if (fl) begin
         for (int i = 0; i < 32; i++) m_val[i] = 0;
      end else if (fi) begin
         found = 0;
         for (int i = 0; i < 32; i++)
            if (!found && !m_val[i]) begin found = 1; idx = i; end
         if (!found) begin idx = m_ptr; m_ptr = (m_ptr + 1) % 32; end
         m_val[idx] = 1; m_tag[idx] = fv; m_ppn[idx] = fp; m_perm[idx] = fm;
      end
   endtask

   task automatic look(bit [63:0] va, bit wr, bit us);
      step(0, 0, '0, '0, '0, va, wr, us);
   endtask

   task automatic fill(bit [29:0] v, bit [20:0] p, bit [3:0] m);
      step(0, 1, v, p, m, mkva(~v, 2'b00, 19'h0, 13'h0), 0, 0);
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   always @(posedge clk) begin
      n_cyc++;
      if (n_cyc > 150000) begin
         n_bad++;
         $display("FAIL watchdog act=%0d exp=<150000", n_cyc);
         summary();
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      cur_tag = "R1";
      for (int k = 0; k < 4; k++) look(mkva(pool(k), 2'(k), 19'h5, 13'h1), 0, 0);
      #1 chk("R1", hit_o, 0);

      // R6: fill not visible in its own cycle, visible next
      cur_tag = "R6";
      step(0, 1, pool(0), 21'h1A2B3, 4'hF, mkva(pool(0), 2'b00, 19'h0, 13'h10), 0, 0);
      look(mkva(pool(0), 2'b00, 19'h0, 13'h10), 0, 0);

      // R2 / R11: hit with varied offsets and ignored middle bits
      cur_tag = "R11";
      for (int k = 0; k < 6; k++)
         look(mkva(pool(0), 2'(k), 19'(k * 40503), 13'(k * 1237)), k[0], k[1]);
      cur_tag = "R2";
      look(mkva(pool(0), 2'b11, 19'h7FFFF, 13'h1FFF), 0, 0);

      // R4: every permission pattern against every mode/access pair
      cur_tag = "R4";
      for (int p = 0; p < 16; p++) fill(pool(1 + p), 21'(p + 100), 4'(p));
      for (int p = 0; p < 16; p++)
         for (int c = 0; c < 4; c++)
            look(mkva(pool(1 + p), 2'b10, 19'h3, 13'(p)), c[0], c[1]);

      // R9: duplicate tag, lowest index wins
      cur_tag = "R9";
      fill(pool(17), 21'h00111, 4'b0001);
      fill(pool(17), 21'h00222, 4'b1110);
      look(mkva(pool(17), 2'b00, 19'h0, 13'h5), 0, 0);
      look(mkva(pool(17), 2'b00, 19'h0, 13'h5), 1, 1);

      // R7 / R8: fill to capacity and beyond, then probe the whole pool
      cur_tag = "R7";
      for (int k = 18; k < 31; k++) fill(pool(k), 21'(k * 3), 4'hF);
      cur_tag = "R8";
      for (int k = 31; k < 45; k++) fill(pool(k), 21'(k * 5), 4'h5);
      for (int k = 0; k < 45; k++) look(mkva(pool(k), 2'b01, 19'h9, 13'(k)), 0, k[0]);

      // R10: flush with a simultaneous fill; fill is dropped
      cur_tag = "R10";
      step(1, 1, pool(50), 21'h0BEEF, 4'hF, mkva(pool(31), 2'b00, 19'h0, 13'h0), 0, 0);
      look(mkva(pool(50), 2'b00, 19'h0, 13'h0), 0, 0);
      for (int k = 0; k < 45; k++) look(mkva(pool(k), 2'b00, 19'h1, 13'h2), 0, 0);
      #1 chk("R10", hit_o, 0);

      // R8: refill past capacity after flush; pointer kept its value
      cur_tag = "R8";
      for (int k = 60; k < 100; k++) fill(pool(k), 21'(k), 4'hA);
      for (int k = 60; k < 100; k++) look(mkva(pool(k), 2'b11, 19'h2, 13'h3), 1, 1);

      // R5 / R3: random mix of lookups, fills and rare flushes
      cur_tag = "R5";
      for (int n = 0; n < 3000; n++) begin
         int r = int'($urandom_range(0, 99));
         bit [29:0] v = pool(int'($urandom_range(0, 59)));
         bit [63:0] va = mkva(v, 2'($urandom), 19'($urandom), 13'($urandom));
         if (r < 2)       step(1, r[0], v, 21'($urandom), 4'($urandom), va, 0, 0);
         else if (r < 30) step(0, 1, v, 21'($urandom), 4'($urandom), va, r[0], r[1]);
         else             look(va, r[0], r[1]);
      end

      summary();
      $finish;
   end

endmodule